// File: doc/BRIEF.md
# IOMMU Control Register Write Decoder

This block is the write side of the control-plane register file of an address translation unit. A host issues one write per cycle with a byte address, a size in bytes and up to 64 bits of data. The block decodes the address, updates the control, queue, stream-table and interrupt configuration registers, and answers every write one cycle later with a response that is either OK or error.

Several registers are 64 bits wide. Each can be written as a whole in one 8-byte access, or one half at a time with 4-byte accesses. The block also keeps three derived values. A write to the low half of a queue base sets that queue's capped log2 size. A stream-table configuration write that selects the two-level format latches a split value and sets a sticky two-level flag. Writes that may give the command-queue consumer new work raise a one-cycle `kick` pulse. A combinational readback port returns the stored registers so that the stored state can be observed.

Top module: `iommu_ctrl_regs`

## Requirements
- R1: After reset every stored register, the acknowledge register, both log2 sizes, the split value, the two-level flag, `kick`, `respValid` and `respErr` are zero.
- R2: Only sizes 4 and 8 (`wrSize` in bytes) are legal. Any other size gives `respErr`=1 with its response, changes no register and raises no `kick`.
- R3: Address bit 16 is cleared before decoding, for writes and for readback alike, so offset 0x10000+X behaves exactly as offset X.
- R4: A 4-byte write to control word 0 (offset 0x20) stores all 32 bits. On the same edge the acknowledge register (offset 0x24, which cannot be written) loads the value with the bits of mask 0xFFFFFC20 cleared. Bit 3 of control word 0 drives `cmdqEnable` and bit 2 drives `evtqEnable`.
- R5: A 64-bit register (error IRQ address 0x68, stream base 0x80, command base 0x90, event base 0xA0, event IRQ address 0xB0) takes an 8-byte write at its base offset whole. It takes a 4-byte write at the base as its low half and a 4-byte write at base+4 as its high half, and the other half is kept. Readback at the base returns 64 bits. Readback at base+4 returns the high half in bits [31:0].
- R6: A write that covers the low half of the command (0x90) or event (0xA0) queue base sets that queue's log2 size to data bits [4:0], clamped to `CQ_MAX_LOG2` or `EQ_MAX_LOG2` (default 19). A high-half-only write leaves the size unchanged.
- R7: A write to the stream configuration (0x88) stores the value. When bits [17:16] equal 1, the split output loads bits [10:6] and the sticky two-level flag sets. Any other format value leaves both untouched.
- R8: A 4-byte write to control word 0 (0x20), to the command producer (0x98) or to the error acknowledge register (0x64) gives `kick`=1 for exactly the response cycle.
- R9: Writes to the command consumer (0x9C), the event producer (0xA8) and the event consumer (0xAC) store the value and do not raise `kick`.
- R10: A legal-size write to an unmapped offset, to the read-only acknowledge offset, or an 8-byte write to a 32-bit register changes nothing and returns OK (`respErr`=0).
- R11: Each write accepted with `wrValid` gives `respValid`=1 in exactly the following cycle. There is no response in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Write request this cycle |
| wrAddr | input | ADDR_W | Byte address of the write |
| wrSize | input | 4 | Access size in bytes |
| wrData | input | 64 | Write data; a 4-byte access uses bits [31:0] |
| respValid | output | 1 | Response for the previous cycle's write |
| respErr | output | 1 | Response is an error (illegal size) |
| kick | output | 1 | One-cycle request to the command consumer |
| rdAddr | input | ADDR_W | Readback byte address |
| rdData | output | 64 | Readback value, zero for unmapped offsets |
| cmdqEnable | output | 1 | Command queue enable from control word 0 |
| evtqEnable | output | 1 | Event queue enable from control word 0 |
| cmdqLog2Size | output | 5 | Capped command queue log2 size |
| evtqLog2Size | output | 5 | Capped event queue log2 size |
| stSplit | output | 5 | Latched stream-table split |
| stTwoLevel | output | 1 | Sticky two-level stream table flag |

## Verification
A decode fault appears one cycle after the write. It shows either as a changed word at the wrong readback offset or as a missing change at the right one, so every write is followed by readback of the target and of a neighbour. A wrong half-select or a missing byte lane shows as a 64-bit value with one half stale. A clamp or format error shows at once on the size, split or flag outputs. A fault in the kick or response logic is visible on the pulse outputs in the single cycle after the write, and the pulses are sampled in that cycle and in the one after.

// File: rtl/iommu_regs_pkg.sv
package iommu_regs_pkg;

  localparam int ALIAS_BIT   = 16;
  localparam int NUM_NARROW  = 14;
  localparam int NUM_WIDE    = 5;
  localparam int NIDX_W      = $clog2(NUM_NARROW);
  localparam int WIDX_W      = $clog2(NUM_WIDE);
  localparam logic [31:0] ACK_CLEAR_MASK = 32'hFFFF_FC20;
  localparam logic [15:0] ACK_OFFSET     = 16'h0024;

  // 32-bit register slots
  localparam int N_CTRL0   = 0;
  localparam int N_CTRL1   = 1;
  localparam int N_CTRL2   = 2;
  localparam int N_IRQCTL  = 3;
  localparam int N_ERRACK  = 4;
  localparam int N_EIDATA  = 5;
  localparam int N_EIATTR  = 6;
  localparam int N_STCFG   = 7;
  localparam int N_CQPROD  = 8;
  localparam int N_CQCONS  = 9;
  localparam int N_EQPROD  = 10;
  localparam int N_EQCONS  = 11;
  localparam int N_QIDATA  = 12;
  localparam int N_QIATTR  = 13;

  // 64-bit register slots
  localparam int W_EIADDR  = 0;
  localparam int W_STBASE  = 1;
  localparam int W_CQBASE  = 2;
  localparam int W_EQBASE  = 3;
  localparam int W_QIADDR  = 4;

  // stream configuration fields
  localparam int FMT_LSB   = 16;
  localparam int SPLIT_LSB = 6;

  typedef struct packed {
    logic              narrowEn;
    logic [NIDX_W-1:0] narrowIdx;
    logic              wideLo;
    logic              wideHi;
    logic [WIDX_W-1:0] wideIdx;
    logic              kick;
    logic              err;
  } wrStrobe_t;

  function automatic logic [15:0] narrowOffset(input int idx);
    case (idx)
      N_CTRL0:  return 16'h0020;
      N_CTRL1:  return 16'h0028;
      N_CTRL2:  return 16'h002C;
      N_IRQCTL: return 16'h0050;
      N_ERRACK: return 16'h0064;
      N_EIDATA: return 16'h0070;
      N_EIATTR: return 16'h0074;
      N_STCFG:  return 16'h0088;
      N_CQPROD: return 16'h0098;
      N_CQCONS: return 16'h009C;
      N_EQPROD: return 16'h00A8;
      N_EQCONS: return 16'h00AC;
      N_QIDATA: return 16'h00B8;
      default:  return 16'h00BC;
    endcase
  endfunction

  function automatic logic [15:0] wideOffset(input int idx);
    case (idx)
      W_EIADDR: return 16'h0068;
      W_STBASE: return 16'h0080;
      W_CQBASE: return 16'h0090;
      W_EQBASE: return 16'h00A0;
      default:  return 16'h00B0;
    endcase
  endfunction

  function automatic logic kicksConsumer(input int idx);
    return (idx == N_CTRL0) || (idx == N_CQPROD) || (idx == N_ERRACK);
  endfunction

  function automatic logic [4:0] capLog2(input logic [4:0] req, input int maxVal);
    return (int'(req) > maxVal) ? 5'(maxVal) : req;
  endfunction

endpackage

// File: rtl/iommu_wr_decode.sv
module iommu_wr_decode
  import iommu_regs_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrSize,
  output wrStrobe_t         stb,
  output logic              respValid,
  output logic              respErr,
  output logic              kick
);

  logic [ADDR_W-1:0] offset;
  logic              sizeFour;
  logic              sizeEight;

  always_comb begin
    offset            = wrAddr;
    offset[ALIAS_BIT] = 1'b0;
    sizeFour          = (wrSize == 4'd4);
    sizeEight         = (wrSize == 4'd8);
  end

  always_comb begin
    stb = '0;
    if (wrValid) begin
      stb.err = !(sizeFour || sizeEight);
      for (int i = 0; i < NUM_NARROW; i++) begin
        if (sizeFour && offset == ADDR_W'(narrowOffset(i))) begin
          stb.narrowEn  = 1'b1;
          stb.narrowIdx = NIDX_W'(i);
          stb.kick      = kicksConsumer(i);
        end
      end
      for (int i = 0; i < NUM_WIDE; i++) begin
        if (offset == ADDR_W'(wideOffset(i))) begin
          if (sizeEight) begin
            stb.wideLo  = 1'b1;
            stb.wideHi  = 1'b1;
            stb.wideIdx = WIDX_W'(i);
          end else if (sizeFour) begin
            stb.wideLo  = 1'b1;
            stb.wideIdx = WIDX_W'(i);
          end
        end
        if (sizeFour && offset == ADDR_W'(wideOffset(i) + 16'd4)) begin
          stb.wideHi  = 1'b1;
          stb.wideIdx = WIDX_W'(i);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respErr   <= 1'b0;
      kick      <= 1'b0;
    end else begin
      respValid <= wrValid;
      respErr   <= stb.err;
      kick      <= stb.kick;
    end
  end

endmodule

// File: rtl/iommu_reg_bank.sv
module iommu_reg_bank
  import iommu_regs_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CQ_MAX_LOG2 = 19,
  parameter int EQ_MAX_LOG2 = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         stb,
  input  logic [63:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [63:0]       rdData,
  output logic [31:0]       ctrl0,
  output logic [4:0]        cmdqLog2,
  output logic [4:0]        evtqLog2,
  output logic [4:0]        split,
  output logic              twoLevel
);

  logic [31:0] narrowQ [NUM_NARROW];
  logic [63:0] wideQ   [NUM_WIDE];
  logic [31:0] ackQ;
  logic [31:0] hiSource;

  // An 8-byte write sets both strobes; a lone high strobe is a 4-byte write at base+4
  assign hiSource = stb.wideLo ? wrData[63:32] : wrData[31:0];

  for (genvar n = 0; n < NUM_NARROW; n++) begin : g_narrow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        narrowQ[n] <= '0;
      end else if (stb.narrowEn && stb.narrowIdx == NIDX_W'(n)) begin
        narrowQ[n] <= wrData[31:0];
      end
    end
  end

  for (genvar w = 0; w < NUM_WIDE; w++) begin : g_wide
    always_ff @(posedge clk) begin
      if (!rstN) begin
        wideQ[w] <= '0;
      end else if (stb.wideIdx == WIDX_W'(w)) begin
        if (stb.wideLo) wideQ[w][31:0]  <= wrData[31:0];
        if (stb.wideHi) wideQ[w][63:32] <= hiSource;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackQ     <= '0;
      cmdqLog2 <= '0;
      evtqLog2 <= '0;
      split    <= '0;
      twoLevel <= 1'b0;
    end else begin
      if (stb.narrowEn && stb.narrowIdx == NIDX_W'(N_CTRL0))
        ackQ <= wrData[31:0] & ~ACK_CLEAR_MASK;
      if (stb.wideLo && stb.wideIdx == WIDX_W'(W_CQBASE))
        cmdqLog2 <= capLog2(wrData[4:0], CQ_MAX_LOG2);
      if (stb.wideLo && stb.wideIdx == WIDX_W'(W_EQBASE))
        evtqLog2 <= capLog2(wrData[4:0], EQ_MAX_LOG2);
      if (stb.narrowEn && stb.narrowIdx == NIDX_W'(N_STCFG)
          && wrData[FMT_LSB+1:FMT_LSB] == 2'd1) begin
        split    <= wrData[SPLIT_LSB+4:SPLIT_LSB];
        twoLevel <= 1'b1;
      end
    end
  end

  logic [ADDR_W-1:0] rdOff;

  always_comb begin
    rdOff            = rdAddr;
    rdOff[ALIAS_BIT] = 1'b0;
    rdData           = '0;
    if (rdOff == ADDR_W'(ACK_OFFSET)) rdData = {32'd0, ackQ};
    for (int i = 0; i < NUM_NARROW; i++)
      if (rdOff == ADDR_W'(narrowOffset(i))) rdData = {32'd0, narrowQ[i]};
    for (int i = 0; i < NUM_WIDE; i++) begin
      if (rdOff == ADDR_W'(wideOffset(i)))         rdData = wideQ[i];
      if (rdOff == ADDR_W'(wideOffset(i) + 16'd4)) rdData = {32'd0, wideQ[i][63:32]};
    end
  end

  assign ctrl0 = narrowQ[N_CTRL0];

endmodule

// File: rtl/iommu_ctrl_regs.sv
module iommu_ctrl_regs
  import iommu_regs_pkg::*;
#(
  parameter int ADDR_W      = 20,
  parameter int CQ_MAX_LOG2 = 19,
  parameter int EQ_MAX_LOG2 = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [3:0]        wrSize,
  input  logic [63:0]       wrData,
  output logic              respValid,
  output logic              respErr,
  output logic              kick,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [63:0]       rdData,
  output logic              cmdqEnable,
  output logic              evtqEnable,
  output logic [4:0]        cmdqLog2Size,
  output logic [4:0]        evtqLog2Size,
  output logic [4:0]        stSplit,
  output logic              stTwoLevel
);

  wrStrobe_t   stb;
  logic [31:0] ctrl0;

  iommu_wr_decode #(.ADDR_W(ADDR_W)) u_decode (
    .clk       (clk),
    .rstN      (rstN),
    .wrValid   (wrValid),
    .wrAddr    (wrAddr),
    .wrSize    (wrSize),
    .stb       (stb),
    .respValid (respValid),
    .respErr   (respErr),
    .kick      (kick)
  );

  iommu_reg_bank #(
    .ADDR_W      (ADDR_W),
    .CQ_MAX_LOG2 (CQ_MAX_LOG2),
    .EQ_MAX_LOG2 (EQ_MAX_LOG2)
  ) u_bank (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .ctrl0    (ctrl0),
    .cmdqLog2 (cmdqLog2Size),
    .evtqLog2 (evtqLog2Size),
    .split    (stSplit),
    .twoLevel (stTwoLevel)
  );

  assign cmdqEnable = ctrl0[3];
  assign evtqEnable = ctrl0[2];

endmodule

// File: rtl/iommu_ctrl_regs_chk.sv
module iommu_ctrl_regs_chk #(
  parameter int CQ_MAX_LOG2 = 19,
  parameter int EQ_MAX_LOG2 = 19
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrValid,
  input logic [3:0] wrSize,
  input logic       respValid,
  input logic       respErr,
  input logic       kick,
  input logic [4:0] cmdqLog2Size,
  input logic [4:0] evtqLog2Size,
  input logic [4:0] stSplit,
  input logic       stTwoLevel
);

  logic badSize;
  assign badSize = (wrSize != 4'd4) && (wrSize != 4'd8);

  assert_resp_follows_R11: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> respValid);
  assert_no_spurious_resp_R11: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> !respValid);
  assert_bad_size_error_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && badSize |=> respErr && !kick);
  assert_bad_size_keeps_state_R2: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && badSize |=> $stable(cmdqLog2Size) && $stable(evtqLog2Size)
                          && $stable(stSplit) && $stable(stTwoLevel));
  assert_err_needs_resp_R2: assert property (@(posedge clk) disable iff (!rstN)
    respErr |-> respValid);
  assert_kick_on_ok_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    kick |-> respValid && !respErr);
  assert_cq_capped_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(cmdqLog2Size) <= CQ_MAX_LOG2);
  assert_eq_capped_R6: assert property (@(posedge clk) disable iff (!rstN)
    int'(evtqLog2Size) <= EQ_MAX_LOG2);
  assert_two_level_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    stTwoLevel |=> stTwoLevel);
  assert_state_only_by_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wrValid |=> $stable(stSplit) && $stable(stTwoLevel)
                 && $stable(cmdqLog2Size) && $stable(evtqLog2Size));

endmodule

bind iommu_ctrl_regs iommu_ctrl_regs_chk #(
  .CQ_MAX_LOG2 (CQ_MAX_LOG2),
  .EQ_MAX_LOG2 (EQ_MAX_LOG2)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .wrValid      (wrValid),
  .wrSize       (wrSize),
  .respValid    (respValid),
  .respErr      (respErr),
  .kick         (kick),
  .cmdqLog2Size (cmdqLog2Size),
  .evtqLog2Size (evtqLog2Size),
  .stSplit      (stSplit),
  .stTwoLevel   (stTwoLevel)
);

// File: tb/iommu_ctrl_regs_test.sv
module iommu_ctrl_regs_test;

  localparam int ADDR_W = 20;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrValid = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [3:0]        wrSize = 4'd4;
  logic [63:0]       wrData = '0;
  logic              respValid, respErr, kick;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [63:0]       rdData;
  logic              cmdqEnable, evtqEnable, stTwoLevel;
  logic [4:0]        cmdqLog2Size, evtqLog2Size, stSplit;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  iommu_ctrl_regs #(.ADDR_W(ADDR_W)) uut (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrSize(wrSize), .wrData(wrData), .respValid(respValid),
    .respErr(respErr), .kick(kick), .rdAddr(rdAddr), .rdData(rdData),
    .cmdqEnable(cmdqEnable), .evtqEnable(evtqEnable),
    .cmdqLog2Size(cmdqLog2Size), .evtqLog2Size(evtqLog2Size),
    .stSplit(stSplit), .stTwoLevel(stTwoLevel)
  );

  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one write; checks response, error and kick in the response cycle, and the idle cycle after
  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [3:0] sz,
                         input logic [63:0] d, input logic expErr, input logic expKick);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrSize = sz; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
    check("R11 respValid", {63'd0, respValid}, 64'd1);
    check("R2 respErr", {63'd0, respErr}, {63'd0, expErr});
    check("R8 kick", {63'd0, kick}, {63'd0, expKick});
    @(negedge clk);
    check("R11 single response", {62'd0, respValid, kick}, 64'd0);
  endtask

  task automatic readCheck(input string tag, input logic [ADDR_W-1:0] a, input logic [63:0] exp);
    rdAddr = a;
    #1;
    check(tag, rdData, exp);
  endtask

  task automatic testReset();
    check("R1 resp/kick", {61'd0, respValid, respErr, kick}, 64'd0);
    check("R1 derived", {44'd0, cmdqLog2Size, evtqLog2Size, stSplit, stTwoLevel, cmdqEnable, evtqEnable}, 64'd0);
    readCheck("R1 ctrl0", 20'h00020, 64'd0);
    readCheck("R1 ack", 20'h00024, 64'd0);
    readCheck("R1 stream base", 20'h00080, 64'd0);
  endtask

  task automatic testCtrl0();
    doWrite(20'h00020, 4'd4, 64'hFFFF_FFFF, 1'b0, 1'b1);
    readCheck("R4 ctrl0 full", 20'h00020, 64'hFFFF_FFFF);
    readCheck("R4 ack masked", 20'h00024, 64'h0000_03DF);
    check("R4 enables", {62'd0, cmdqEnable, evtqEnable}, 64'd3);
    doWrite(20'h00020, 4'd4, 64'h0000_0004, 1'b0, 1'b1);
    check("R4 enables event only", {62'd0, cmdqEnable, evtqEnable}, 64'd1);
    readCheck("R4 ack second", 20'h00024, 64'h4);
  endtask

  task automatic testAlias();
    doWrite(20'h10028, 4'd4, 64'h1234_5678, 1'b0, 1'b0);
    readCheck("R3 alias write", 20'h00028, 64'h1234_5678);
    readCheck("R3 alias read", 20'h10028, 64'h1234_5678);
    readCheck("R3 neighbour untouched", 20'h0002C, 64'd0);
  endtask

  task automatic testWide();
    doWrite(20'h00080, 4'd8, 64'h1122_3344_5566_7788, 1'b0, 1'b0);
    readCheck("R5 whole write", 20'h00080, 64'h1122_3344_5566_7788);
    doWrite(20'h00080, 4'd4, 64'hAAAA_AAAA, 1'b0, 1'b0);
    readCheck("R5 low half", 20'h00080, 64'h1122_3344_AAAA_AAAA);
    doWrite(20'h00084, 4'd4, 64'hBBBB_BBBB, 1'b0, 1'b0);
    readCheck("R5 high half", 20'h00080, 64'hBBBB_BBBB_AAAA_AAAA);
    readCheck("R5 high readback", 20'h00084, 64'hBBBB_BBBB);
    doWrite(20'h000B4, 4'd4, 64'h0000_00C3, 1'b0, 1'b0);
    readCheck("R5 irq addr high only", 20'h000B0, 64'h0000_00C3_0000_0000);
  endtask

  task automatic testLog2();
    doWrite(20'h00090, 4'd4, 64'hDEAD_0005, 1'b0, 1'b0);
    check("R6 cmd size", {59'd0, cmdqLog2Size}, 64'd5);
    doWrite(20'h00094, 4'd4, 64'h0000_0003, 1'b0, 1'b0);
    check("R6 high write keeps size", {59'd0, cmdqLog2Size}, 64'd5);
    readCheck("R6 cmd base", 20'h00090, 64'h0000_0003_DEAD_0005);
    doWrite(20'h00090, 4'd8, 64'h0000_0001_0000_001F, 1'b0, 1'b0);
    check("R6 cmd clamp", {59'd0, cmdqLog2Size}, 64'd19);
    doWrite(20'h000A0, 4'd8, 64'h0000_0000_0000_0012, 1'b0, 1'b0);
    check("R6 event size", {59'd0, evtqLog2Size}, 64'd18);
    doWrite(20'h100A0, 4'd4, 64'h0000_001E, 1'b0, 1'b0);
    check("R6 event clamp", {59'd0, evtqLog2Size}, 64'd19);
    check("R6 cmd unaffected", {59'd0, cmdqLog2Size}, 64'd19);
  endtask

  task automatic testStreamCfg();
    doWrite(20'h00088, 4'd4, 64'h0000_01C0, 1'b0, 1'b0);
    check("R7 format 0 no latch", {58'd0, stSplit, stTwoLevel}, 64'd0);
    readCheck("R7 stored fmt0", 20'h00088, 64'h0000_01C0);
    doWrite(20'h00088, 4'd4, 64'h0001_0240, 1'b0, 1'b0);
    check("R7 format 1 latch", {58'd0, stSplit, stTwoLevel}, {58'd0, 5'd9, 1'b1});
    doWrite(20'h00088, 4'd4, 64'h0002_00C0, 1'b0, 1'b0);
    check("R7 format 2 keeps", {58'd0, stSplit, stTwoLevel}, {58'd0, 5'd9, 1'b1});
    readCheck("R7 stored fmt2", 20'h00088, 64'h0002_00C0);
  endtask

  task automatic testKicks();
    doWrite(20'h00098, 4'd4, 64'h0000_0010, 1'b0, 1'b1);
    readCheck("R8 producer stored", 20'h00098, 64'h10);
    doWrite(20'h10064, 4'd4, 64'h0000_0001, 1'b0, 1'b1);
    doWrite(20'h0009C, 4'd4, 64'h0000_0007, 1'b0, 1'b0);
    readCheck("R9 cmd consumer", 20'h0009C, 64'h7);
    doWrite(20'h000A8, 4'd4, 64'h0000_0021, 1'b0, 1'b0);
    readCheck("R9 event producer", 20'h000A8, 64'h21);
    doWrite(20'h000AC, 4'd4, 64'h0000_0022, 1'b0, 1'b0);
    readCheck("R9 event consumer", 20'h000AC, 64'h22);
  endtask

  task automatic testBadSize();
    doWrite(20'h00028, 4'd2, 64'hFFFF_FFFF, 1'b1, 1'b0);
    readCheck("R2 ctrl1 unchanged", 20'h00028, 64'h1234_5678);
    doWrite(20'h00020, 4'd1, 64'h0000_0000, 1'b1, 1'b0);
    readCheck("R2 ctrl0 unchanged", 20'h00020, 64'h4);
    doWrite(20'h00090, 4'd0, 64'h0000_0002, 1'b1, 1'b0);
    check("R2 size unchanged", {59'd0, cmdqLog2Size}, 64'd19);
  endtask

  task automatic testIgnored();
    doWrite(20'h01000, 4'd4, 64'hFFFF_FFFF, 1'b0, 1'b0);
    readCheck("R10 unmapped reads zero", 20'h01000, 64'd0);
    doWrite(20'h00028, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0);
    readCheck("R10 wide to narrow ignored", 20'h00028, 64'h1234_5678);
    readCheck("R10 next word untouched", 20'h0002C, 64'd0);
    doWrite(20'h00024, 4'd4, 64'hFFFF_FFFF, 1'b0, 1'b0);
    readCheck("R10 ack read-only", 20'h00024, 64'h4);
    doWrite(20'h00084, 4'd8, 64'h0, 1'b0, 1'b0);
    readCheck("R10 misplaced wide", 20'h00080, 64'hBBBB_BBBB_AAAA_AAAA);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCtrl0();
    testAlias();
    testWide();
    testLog2();
    testStreamCfg();
    testKicks();
    testBadSize();
    testIgnored();
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule